// File: doc/BRIEF.md
# Multi-Lane Wide Trace Readback Buffer

This block records a stream of wide trace words and lets a 32-bit host read them back. Every cycle in which the capture strobe is high, one 256-bit word is stored at the write position, which then moves on by one, modulo the buffer depth of 512 entries. Once the write position passes the last entry it wraps, and from then on the oldest entries are overwritten.

A stored entry is too wide for the host bus, so the host reads it one 32-bit lane at a time. There are eight lanes per entry. The host interface has four word-addressed registers: a lane select, a read pointer, a data port and a read-only copy of the write position. Each data read returns the selected lane of the entry at the read pointer and then advances the pointer by one.

To dump one lane with the oldest entry first, the host does the following:
1. It selects the lane.
2. It reads the write position.
3. It writes that value into the read pointer.
4. It reads the data port 512 times.

Top module: `trace_readback_buf`

## Requirements
- R1: Each cycle with `cap_valid` high stores `cap_word` at the write position, which then advances by one and wraps from 511 to 0. A cycle with `cap_valid` low leaves the write position and the stored entries unchanged.
- R2: `host_addr` selects one of four registers: 0 is the lane select, 1 is the read pointer, 2 is the data port and 3 is the write position.
- R3: A write to the lane select keeps only `host_wdata[2:0]` and ignores the upper bits. A read of the lane select returns the stored lane number, zero-extended.
- R4: A read of the data port returns bits [32*L+31:32*L] of the entry at the read pointer, where L is the selected lane. The value appears on `host_rdata` one cycle after the read strobe.
- R5: Each data-port read advances the read pointer by one, and 511 wraps to 0. Reads of the other registers leave the read pointer unchanged.
- R6: A write to the read pointer loads `host_wdata[8:0]` and ignores the upper bits. Reading the read pointer returns that value, zero-extended.
- R7: The write position register is read-only. Writes to offset 3 change neither it nor the capture order.
- R8: After the buffer has wrapped, loading the read pointer with the write position and then reading the data port 512 times returns one lane of every entry, oldest first, and leaves the read pointer back at its starting value.
- R9: A data read in the same cycle as a capture to the same entry returns the entry's previous contents. The new contents are returned by the next read of that entry.
- R10: After a synchronous active-low reset, the lane select, the read pointer, the write position and `host_rdata` are all zero.
- R11: `host_rdata` keeps its value in every cycle without a read strobe, including write cycles.
- R12: A cycle with both `host_wr` and `host_rd` high is handled as a write only. The read strobe in that cycle is ignored: the read pointer does not advance and `host_rdata` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_valid | input | 1 | Capture strobe |
| cap_word | input | 256 | Trace word to store |
| host_addr | input | 2 | Register word offset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |

## Verification
The capture side is driven with back-to-back strobes, with strobes separated by idle cycles, and with enough words to wrap the buffer, so that counting only valid cycles can be told apart from counting every cycle. Each lane of every entry holds a value that depends on both the entry number and the lane number. A lane-select error or an off-by-one in the pointer therefore returns a different value rather than a plausible one. The register sequences cover the upper bits of the lane select and read pointer, a write to the read-only register, and a pointer wrap at 511. A full oldest-first dump is run on every lane. Directed cases cover a capture and a read that collide on the same entry, and a cycle with both strobes high.

// File: rtl/trace_rb_pkg.sv
// Shared definitions for the trace readback buffer.
// Assumes a host bus that addresses 32-bit words, with a 2-bit offset.
package trace_rb_pkg;
    typedef enum logic [1:0] {
        REG_LANE = 2'd0,   // lane select
        REG_RPTR = 2'd1,   // read pointer
        REG_DATA = 2'd2,   // data port, auto-increment
        REG_WPTR = 2'd3    // write position, read-only
    } reg_sel_e;
endpackage

// File: rtl/trace_rb_wptr.sv
// Write position counter for the capture side.
// Advances once for every valid capture strobe. Assumes DEPTH is a power of
// two, so the wrap to zero comes from the natural overflow of PTR_W bits.
module trace_rb_wptr #(
    parameter int DEPTH = 512,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_valid,
    output logic [PTR_W-1:0] wptr
);
    // Advance the write position on each accepted capture.
    always_ff @(posedge clk) begin
        if (!rst_n)         wptr <= '0;
        else if (cap_valid) wptr <= wptr + 1'b1;
    end

    AST_WPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |=> wptr == PTR_W'($past(wptr) + 1'b1));  // R1
    AST_WPTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_valid |=> $stable(wptr));  // R1
endmodule

// File: rtl/trace_rb_lanes.sv
// Lane-split trace storage.
// Each lane is a separate DEPTH x LANE_W array with one write port and one
// combinational read port. A capture writes all lanes at once. The read port
// returns the selected lane of the entry at rd_addr. A read and a capture
// to the same entry in one cycle see the old contents.
// Assumes LANES is a power of two.
module trace_rb_lanes #(
    parameter int DEPTH  = 512,
    parameter int LANES  = 8,
    parameter int LANE_W = 32,
    parameter int PTR_W  = $clog2(DEPTH),
    parameter int SEL_W  = $clog2(LANES)
) (
    input  logic                    clk,
    input  logic                    cap_valid,
    input  logic [PTR_W-1:0]        cap_addr,
    input  logic [LANES*LANE_W-1:0] cap_word,
    input  logic [PTR_W-1:0]        rd_addr,
    input  logic [SEL_W-1:0]        rd_lane,
    output logic [LANE_W-1:0]       rd_data
);
    logic [LANE_W-1:0] lane_q [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Store this lane's slice of the captured word.
        always_ff @(posedge clk) begin
            if (cap_valid) mem[cap_addr] <= cap_word[g*LANE_W +: LANE_W];
        end

        assign lane_q[g] = mem[rd_addr];
    end

    // Pick the slice the host has selected.
    always_comb rd_data = lane_q[rd_lane];
endmodule

// File: rtl/trace_rb_host.sv
// Host register file.
// Holds the lane select and the read pointer, and drives the registered
// read data. Assumes at most one register access per cycle. When both
// strobes are high, the cycle is treated as a write and the read is dropped.
module trace_rb_host
    import trace_rb_pkg::*;
#(
    parameter int LANE_W = 32,
    parameter int PTR_W  = 9,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [LANE_W-1:0] host_wdata,
    input  logic [PTR_W-1:0]  wptr,
    input  logic [LANE_W-1:0] lane_data,
    output logic [PTR_W-1:0]  rptr,
    output logic [SEL_W-1:0]  lane_sel,
    output logic [LANE_W-1:0] host_rdata
);
    reg_sel_e sel;
    logic     rd_take;

    // Decode the register offset and qualify the read strobe.
    always_comb begin
        sel     = reg_sel_e'(host_addr);
        rd_take = host_rd && !host_wr;
    end

    // Lane select register: keeps only the low SEL_W bits.
    always_ff @(posedge clk) begin
        if (!rst_n)                           lane_sel <= '0;
        else if (host_wr && sel == REG_LANE)  lane_sel <= host_wdata[SEL_W-1:0];
    end

    // Read pointer: loaded by the host, advanced by each data-port read.
    always_ff @(posedge clk) begin
        if (!rst_n)                           rptr <= '0;
        else if (host_wr && sel == REG_RPTR)  rptr <= host_wdata[PTR_W-1:0];
        else if (rd_take && sel == REG_DATA)  rptr <= rptr + 1'b1;
    end

    // Registered read data, updated only by an accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n) host_rdata <= '0;
        else if (rd_take) begin
            case (sel)
                REG_LANE: host_rdata <= LANE_W'(lane_sel);
                REG_RPTR: host_rdata <= LANE_W'(rptr);
                REG_DATA: host_rdata <= lane_data;
                default:  host_rdata <= LANE_W'(wptr);
            endcase
        end
    end

    AST_RPTR_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr && host_addr == 2'd2) |=> rptr == PTR_W'($past(rptr) + 1'b1));  // R5
    AST_RPTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 2'd1) |=> rptr == $past(host_wdata[PTR_W-1:0]));  // R6
    AST_RPTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && host_addr == 2'd1) && !(host_rd && host_addr == 2'd2) |=> $stable(rptr));  // R5
    AST_LANE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && host_addr == 2'd0) |=> $stable(lane_sel));  // R3
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_rd && !host_wr) |=> $stable(host_rdata));  // R11
    AST_BOTH_IS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_rd && host_addr == 2'd2) |=> $stable(rptr));  // R12
endmodule

// File: rtl/trace_readback_buf.sv
// Top level of the trace readback buffer.
// Connects the capture counter, the lane-split storage and the host
// register file. Assumes DEPTH and LANES are powers of two, and that the
// host data width equals the lane width.
module trace_readback_buf #(
    parameter int DEPTH  = 512,
    parameter int LANES  = 8,
    parameter int LANE_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cap_valid,
    input  logic [LANES*LANE_W-1:0] cap_word,
    input  logic [1:0]              host_addr,
    input  logic                    host_wr,
    input  logic                    host_rd,
    input  logic [LANE_W-1:0]       host_wdata,
    output logic [LANE_W-1:0]       host_rdata
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int SEL_W = $clog2(LANES);

    logic [PTR_W-1:0]  wptr;
    logic [PTR_W-1:0]  rptr;
    logic [SEL_W-1:0]  lane_sel;
    logic [LANE_W-1:0] lane_data;

    trace_rb_wptr #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_wptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_valid (cap_valid),
        .wptr      (wptr)
    );

    trace_rb_lanes #(
        .DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W), .PTR_W(PTR_W), .SEL_W(SEL_W)
    ) u_lanes (
        .clk       (clk),
        .cap_valid (cap_valid),
        .cap_addr  (wptr),
        .cap_word  (cap_word),
        .rd_addr   (rptr),
        .rd_lane   (lane_sel),
        .rd_data   (lane_data)
    );

    trace_rb_host #(.LANE_W(LANE_W), .PTR_W(PTR_W), .SEL_W(SEL_W)) u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_wdata (host_wdata),
        .wptr       (wptr),
        .lane_data  (lane_data),
        .rptr       (rptr),
        .lane_sel   (lane_sel),
        .host_rdata (host_rdata)
    );

    AST_WPTR_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 2'd3 && !cap_valid) |=> $stable(wptr));  // R7
endmodule

// File: tb/trace_readback_buf_tb.sv
module trace_readback_buf_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH  = 512;
    localparam int LANES  = 8;
    localparam int LANE_W = 32;
    localparam int WORD_W = LANES * LANE_W;

    // Register offsets (R2).
    localparam logic [1:0] A_LANE = 2'd0, A_RPTR = 2'd1, A_DATA = 2'd2, A_WPTR = 2'd3;

    typedef struct packed {
        logic [1:0]  op;    // 0 write, 1 read with a fixed expected value, 2 data read from the model
        logic [1:0]  addr;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    // Applied after 600 captures, so the write position is 88.
    localparam vec_t VECS [18] = '{
        '{2'd0, 2'd0, 32'd3,          32'd0,   4'd3},   // R3
        '{2'd1, 2'd0, 32'd0,          32'd3,   4'd3},   // R3
        '{2'd0, 2'd1, 32'd5,          32'd0,   4'd6},   // R6
        '{2'd1, 2'd1, 32'd0,          32'd5,   4'd6},   // R6
        '{2'd2, 2'd2, 32'd0,          32'd0,   4'd4},   // R4
        '{2'd2, 2'd2, 32'd0,          32'd0,   4'd4},   // R4
        '{2'd2, 2'd2, 32'd0,          32'd0,   4'd4},   // R4
        '{2'd1, 2'd1, 32'd0,          32'd8,   4'd5},   // R5
        '{2'd0, 2'd0, 32'hFFFF_FFF9,  32'd0,   4'd3},   // R3 upper bits ignored
        '{2'd1, 2'd0, 32'd0,          32'd1,   4'd3},   // R3
        '{2'd2, 2'd2, 32'd0,          32'd0,   4'd4},   // R4 lane 1
        '{2'd0, 2'd3, 32'd7,          32'd0,   4'd7},   // R7
        '{2'd1, 2'd3, 32'd0,          32'd88,  4'd7},   // R7
        '{2'd0, 2'd1, 32'd511,        32'd0,   4'd5},   // R5
        '{2'd2, 2'd2, 32'd0,          32'd0,   4'd5},   // R5
        '{2'd1, 2'd1, 32'd0,          32'd0,   4'd5},   // R5 wrap
        '{2'd0, 2'd1, 32'h0000_1203,  32'd0,   4'd6},   // R6 upper bits ignored
        '{2'd1, 2'd1, 32'd0,          32'd3,   4'd6}    // R6
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cap_valid = 1'b0;
    logic [WORD_W-1:0] cap_word = '0;
    logic [1:0]        host_addr = '0;
    logic              host_wr = 1'b0;
    logic              host_rd = 1'b0;
    logic [31:0]       host_wdata = '0;
    logic [31:0]       host_rdata;

    int n_chk = 0;
    int n_bad = 0;
    logic [WORD_W-1:0] model [DEPTH];
    int wptr_m = 0;
    int lane_m = 0;
    int rptr_m = 0;
    bit done = 1'b0;

    trace_readback_buf #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_word(cap_word),
        .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [WORD_W-1:0] mk(int k);
        logic [WORD_W-1:0] w;
        for (int l = 0; l < LANES; l++)
            w[l*LANE_W +: LANE_W] = (32'(k) * 32'h9E37_79B1) ^ {l[3:0], 28'h0} ^ 32'(l);
        return w;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic capture(input int k, input bit gap);
        @(negedge clk);
        cap_valid = 1'b1;
        cap_word  = mk(k);
        model[wptr_m] = mk(k);
        wptr_m = (wptr_m + 1) % DEPTH;
        @(negedge clk);
        cap_valid = 1'b0;
        if (gap) @(negedge clk);
    endtask

    task automatic hwrite(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
        v = host_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        check("R10", host_rdata, 32'd0);
        hread(A_LANE, v); check("R10", v, 32'd0);
        hread(A_RPTR, v); check("R10", v, 32'd0);
        hread(A_WPTR, v); check("R10", v, 32'd0);

        // R1: captures separated by idle cycles count once each
        for (int k = 0; k < 3; k++) capture(k, 1'b1);
        hread(A_WPTR, v); check("R1", v, 32'd3);
        for (int k = 3; k < 600; k++) capture(k, (k % 7) == 0);
        hread(A_WPTR, v); check("R1", v, 32'd88);

        // Table walk of register sequences (R2..R7)
        lane_m = 0; rptr_m = 0;
        for (int i = 0; i < 18; i++) begin
            vec_t t = VECS[i];
            string rq = $sformatf("R%0d", t.req);
            if (t.op == 2'd0) begin
                hwrite(t.addr, t.wdata);
                if (t.addr == A_LANE) lane_m = int'(t.wdata[2:0]);
                if (t.addr == A_RPTR) rptr_m = int'(t.wdata[8:0]);
            end else if (t.op == 2'd1) begin
                hread(t.addr, v); check(rq, v, t.exp);
            end else begin
                hread(A_DATA, v);
                check(rq, v, model[rptr_m][lane_m*LANE_W +: LANE_W]);
                rptr_m = (rptr_m + 1) % DEPTH;
            end
        end

        // R8: oldest-first dump of every lane
        for (int l = 0; l < LANES; l++) begin
            hwrite(A_LANE, 32'(l));
            hread(A_WPTR, w);
            hwrite(A_RPTR, w);
            for (int i = 0; i < DEPTH; i++) begin
                hread(A_DATA, v);
                check("R8", v, model[(int'(w) + i) % DEPTH][l*LANE_W +: LANE_W]);
            end
            hread(A_RPTR, v); check("R8", v, w);
        end

        // R9: a capture and a read of the same entry in one cycle
        hwrite(A_LANE, 32'd0);
        hwrite(A_RPTR, 32'(wptr_m));
        @(negedge clk);
        cap_valid = 1'b1; cap_word = mk(9999);
        host_rd = 1'b1; host_addr = A_DATA;
        @(negedge clk);
        cap_valid = 1'b0; host_rd = 1'b0;
        check("R9", host_rdata, model[wptr_m][31:0]);
        model[wptr_m] = mk(9999);
        hwrite(A_RPTR, 32'(wptr_m));
        hread(A_DATA, v); check("R9", v, model[wptr_m][31:0]);
        wptr_m = (wptr_m + 1) % DEPTH;

        // R11: rdata holds across idle and write cycles
        hread(A_RPTR, v);
        hwrite(A_LANE, 32'd5);
        repeat (2) @(negedge clk);
        check("R11", host_rdata, v);

        // R12: both strobes on the data port count as a write only
        hwrite(A_RPTR, 32'd10);
        hread(A_RPTR, v); check("R12", v, 32'd10);
        @(negedge clk);
        host_wr = 1'b1; host_rd = 1'b1; host_addr = A_DATA; host_wdata = 32'hDEAD_BEEF;
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
        check("R12", host_rdata, 32'd10);
        hread(A_RPTR, v); check("R12", v, 32'd10);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule